// File: doc/BRIEF.md
# SD Card Clock Generator with Safe Ratio Switching

This block derives the SD card clock from the host clock. A control word, written through a simple write port, chooses the divide ratio, turns the card clock on or off, and can ask the block to park the card clock whenever the command and data engines report that the bus is idle. Every divided clock is square (equal high and low time). Setting the pass-through bit with no divisor bit set forwards the host clock itself, gated cleanly.

The output is started and stopped only at safe points. When the clock is turned off, or parked because the bus went idle, the current period runs to its end and the output then rests low. The ratio the block runs at is copied from the control word only while the output is stopped. A new ratio written while the clock runs is therefore held back until the clock has stopped and starts again. Two strobes tell the engines that the card clock will rise or fall at the next host clock edge, so they can launch or capture data on the right cycle.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the card clock is low, both edge strobes are low and the output stays stopped until it is enabled.
- R2: Control bit i (i = 0..7) selects division by 2^(i+2). The divided clock is high for 2^(i+1) host cycles and low for 2^(i+1) host cycles.
- R3: With all divisor bits (0..7 and 16) and the pass-through bit 10 clear, the card clock is the host clock divided by 2: one host cycle high, one host cycle low.
- R4: Pass-through bit 10, with no divisor bit set, forwards the host clock: the card clock is high while the host clock is high and low while it is low. While the clock is forwarded, both strobes are held high.
- R5: Bit 16 selects division by 1024 (512 cycles high, 512 low) when the build parameter HAS_DIV1024 is 1. When it is 0, bit 16 selects division by 512 (256 high, 256 low).
- R6: When several ratio bits are set, the largest ratio wins. Any divisor bit overrides pass-through bit 10.
- R7: Bit 8 enables the card clock. If bit 8 is cleared while the clock is high, the high phase still runs its full length, the clock falls and then stays low, and no further strobe is raised.
- R8: Bit 9 enables auto-stop. With bit 9 and bit 8 set, the clock stays low while bus_busy is low and runs while bus_busy is high.
- R9: A new ratio written while the clock is running has no effect on the running clock. The ratio is taken only while the output is stopped, and it applies from the next start.
- R10: pre_rise is high in exactly the host cycle before each rising edge of the divided card clock, and pre_fall in exactly the host cycle before each falling edge.
- R11: From the stopped state, the first rising edge of a divided clock comes at the second host clock edge after the edge that stores the enabling write. pre_rise is high in the cycle between those two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 17 | Control word: bits 0..7 and 16 divisor, 8 enable, 9 auto-stop, 10 pass-through |
| bus_busy | input | 1 | High while the command or data engines need the card clock |
| sd_clk | output | 1 | Card clock |
| pre_rise | output | 1 | The card clock rises at the next host clock edge |
| pre_fall | output | 1 | The card clock falls at the next host clock edge |

## Verification
The bench builds two copies of the block side by side, one with HAS_DIV1024 = 1 and one with HAS_DIV1024 = 0, and drives both with the same stimulus. With both copies, the same bit-16 setting can be seen to give a 512-cycle half period on one and a 256-cycle half period on the other. All eight power-of-two divisors, the divide-by-2 default and the pass-through mode are measured on the first copy. The half-period counter reaches its widest count of 511 there.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // ratio is expressed as log2 of the divide ratio; 0 means pass-through
  localparam int MAX_LOG = 10;
  localparam int LOG_W   = 4;
  localparam int CNT_W   = MAX_LOG - 1;
  localparam int REG_W   = 17;
  localparam int NDIV    = 8;

  // control word bit positions (software decodes these)
  localparam int B_EN    = 8;
  localparam int B_AUTO  = 9;
  localparam int B_PASS  = 10;
  localparam int B_D1K   = 16;

  typedef logic [LOG_W-1:0] ratio_log_t;

  // ascending priority: later (larger) selections overwrite smaller ones
  function automatic ratio_log_t ratio_log(input logic [NDIV-1:0] dv,
                                           input logic            d1k,
                                           input logic            pass,
                                           input bit              has1k);
    ratio_log_t k;
    k = ratio_log_t'(1);
    if (pass) k = '0;
    for (int i = 0; i < NDIV; i++) begin
      if (dv[i]) k = ratio_log_t'(i + 2);
    end
    if (d1k) k = has1k ? ratio_log_t'(MAX_LOG) : ratio_log_t'(MAX_LOG - 1);
    return k;
  endfunction

endpackage

// File: rtl/sdclk_ctl.sv
module sdclk_ctl
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             stopped,
  output logic             en_o,
  output logic             auto_o,
  output ratio_log_t       sel_k_o
);

  logic [NDIV-1:0] dv_q, dv_d;
  logic            d1k_q, d1k_d;
  logic            pass_q, pass_d;
  logic            en_q, en_d;
  logic            auto_q, auto_d;
  ratio_log_t      act_q, reg_k;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[B_D1K-1:B_PASS+1];

  always_comb begin
    dv_d   = dv_q;
    d1k_d  = d1k_q;
    pass_d = pass_q;
    en_d   = en_q;
    auto_d = auto_q;
    if (we) begin
      dv_d   = wdata[NDIV-1:0];
      d1k_d  = wdata[B_D1K];
      pass_d = wdata[B_PASS];
      en_d   = wdata[B_EN];
      auto_d = wdata[B_AUTO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= '0;
      d1k_q  <= 1'b0;
      pass_q <= 1'b0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      dv_q   <= dv_d;
      d1k_q  <= d1k_d;
      pass_q <= pass_d;
      en_q   <= en_d;
      auto_q <= auto_d;
    end
  end

  assign reg_k = ratio_log(dv_q, d1k_q, pass_q, HAS_DIV1024);

  // applied ratio follows the register only while the output is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= ratio_log_t'(1);
    else if (stopped) act_q <= reg_k;
  end

  assign sel_k_o = stopped ? reg_k : act_q;
  assign en_o    = en_q;
  assign auto_o  = auto_q;

  // R9: while running, the ratio in use never moves
  a_r9_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && $past(!stopped)) |-> $stable(sel_k_o));

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
  import sdclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want,
  input  ratio_log_t half_k,
  output logic       sclk_o,
  output logic       run_o,
  output logic       pre_rise_o,
  output logic       pre_fall_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   one_sh;
  logic             sclk_q, sclk_d;
  logic             run_q, run_d;
  logic             at_end, rise_go, fall_go, stop_go;

  // half period in host cycles is 2^(k-1)
  assign one_sh = {{CNT_W{1'b0}}, 1'b1} << LOG_W'(half_k - 4'd1);
  assign lim    = CNT_W'(one_sh - 1'b1);

  assign at_end  = run_q && (cnt_q == lim);
  assign rise_go = !sclk_q && want && (!run_q || at_end);
  assign fall_go = sclk_q && at_end;
  assign stop_go = run_q && !sclk_q && at_end && !want;

  always_comb begin
    sclk_d = sclk_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    if (rise_go) begin
      sclk_d = 1'b1;
      run_d  = 1'b1;
      cnt_d  = '0;
    end else if (fall_go) begin
      sclk_d = 1'b0;
      cnt_d  = '0;
    end else if (stop_go) begin
      run_d  = 1'b0;
      cnt_d  = '0;
    end else if (run_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sclk_o     = sclk_q;
  assign run_o      = run_q;
  assign pre_rise_o = rise_go;
  assign pre_fall_o = fall_go;

  // R7: the divider only ever stops with the clock low, after a low phase
  a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (!sclk_q && $past(!sclk_q)));
  // R10: each edge is announced one cycle ahead
  a_r10_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(pre_rise_o));
  a_r10_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> $past(pre_fall_o));
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_rise_o && pre_fall_o));

endmodule

// File: rtl/sdclk_pass_gate.sv
module sdclk_pass_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic run_o,
  output logic gate_o
);

  logic run_q, gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= want;
  end

  // gate opens and closes only while the host clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_q;
  end

  assign run_o  = run_q;
  assign gate_o = gate_q;

endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             bus_busy,
  output logic             sd_clk,
  output logic             pre_rise,
  output logic             pre_fall
);

  logic [1:0]  rst_sync_q;
  logic        rst_s;
  logic        en, auto_stop, want_all;
  logic        core_run, core_clk, core_pr, core_pf;
  logic        pass_run, pass_gate;
  logic        stopped, pass_sel;
  ratio_log_t  sel_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign want_all = en && !(auto_stop && !bus_busy);
  assign stopped  = !core_run && !pass_run && !pass_gate;
  assign pass_sel = (sel_k == '0);

  sdclk_ctl #(.HAS_DIV1024(HAS_DIV1024)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_s),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .stopped (stopped),
    .en_o    (en),
    .auto_o  (auto_stop),
    .sel_k_o (sel_k)
  );

  sdclk_div_core u_core (
    .clk        (clk),
    .rst_n      (rst_s),
    .want       (want_all && !pass_sel),
    .half_k     (sel_k),
    .sclk_o     (core_clk),
    .run_o      (core_run),
    .pre_rise_o (core_pr),
    .pre_fall_o (core_pf)
  );

  sdclk_pass_gate u_pass (
    .clk    (clk),
    .rst_n  (rst_s),
    .want   (want_all && pass_sel),
    .run_o  (pass_run),
    .gate_o (pass_gate)
  );

  assign sd_clk   = core_clk | (clk & pass_gate);
  assign pre_rise = core_pr | pass_run;
  assign pre_fall = core_pf | pass_run;

  // R4: the divider and the pass-through path never run together
  a_r4_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    !(core_run && pass_run));
  // R1: with the clock disabled nothing is announced
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_s)
    (!en && stopped) |-> (!pre_rise && !pre_fall));

endmodule

// File: tb/sd_clk_gen_tb.sv
`timescale 1ns/1ps
module sd_clk_gen_tb;

  localparam logic [16:0] EN   = 17'h00100;
  localparam logic [16:0] AUTO = 17'h00200;
  localparam logic [16:0] PASS = 17'h00400;
  localparam logic [16:0] D1K  = 17'h10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic        bus_busy = 1'b0;
  logic        sd_clk_a, pr_a, pf_a;
  logic        sd_clk_b, pr_b, pf_b;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  sd_clk_gen #(.HAS_DIV1024(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_busy(bus_busy), .sd_clk(sd_clk_a), .pre_rise(pr_a), .pre_fall(pf_a));

  sd_clk_gen #(.HAS_DIV1024(1'b0)) u_dut_no1k (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_busy(bus_busy), .sd_clk(sd_clk_b), .pre_rise(pr_b), .pre_fall(pf_b));

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(input bit b, output bit s, output bit pr, output bit pf);
    @(negedge clk);
    #1;
    s  = b ? sd_clk_b : sd_clk_a;
    pr = b ? pr_b : pr_a;
    pf = b ? pf_b : pf_a;
  endtask

  // measure one full period; edges must each be announced one cycle ahead
  task automatic measure(input bit b, input int exp_h, input string tag);
    int hi = 0;
    int lo = 0;
    int n = 0;
    int st = 0;
    bit ps, ppr, ppf, s, pr, pf;
    bit sok = 1'b1;
    sample(b, ps, ppr, ppf);
    while (st < 3 && n < 4000) begin
      sample(b, s, pr, pf);
      n++;
      if ((s && !ps) != ppr) sok = 1'b0;
      if ((!s && ps) != ppf) sok = 1'b0;
      case (st)
        0: if (s && !ps) begin st = 1; hi = 1; end
        1: if (s) hi++; else begin st = 2; lo = 1; end
        2: if (!s) lo++; else st = 3;
        default: ;
      endcase
      ps = s; ppr = pr; ppf = pf;
    end
    chk(hi == exp_h, {tag, " high time"}, hi, exp_h);
    chk(lo == exp_h, {tag, " low time"}, lo, exp_h);
    chk(sok, {tag, " R10 edge strobes"}, int'(sok), 1);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit s, pr, pf;
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      sample(1'b0, s, pr, pf);
      if (s || pr || pf) ok = 1'b0;
    end
    chk(ok, tag, int'(ok), 1);
  endtask

  task automatic restart(input logic [16:0] code);
    wr(17'h0);
    idle(1100);
    wr(code | EN);
  endtask

  task automatic t_reset;
    expect_quiet(10, "R1 reset state quiet");
  endtask

  task automatic t_start;
    bit s, pr, pf;
    wr(17'h1 | EN);
    #1;
    chk(pr_a == 1'b1, "R11 pre_rise after enabling write", int'(pr_a), 1);
    chk(sd_clk_a == 1'b0, "R11 clock still low", int'(sd_clk_a), 0);
    sample(1'b0, s, pr, pf);
    chk(s == 1'b1, "R11 first rising edge", int'(s), 1);
  endtask

  task automatic t_divisors;
    for (int i = 0; i < 8; i++) begin
      restart(17'(1) << i);
      measure(1'b0, 1 << (i + 1), $sformatf("R2 divisor bit %0d", i));
    end
  endtask

  task automatic t_div2;
    restart(17'h0);
    measure(1'b0, 1, "R3 all-zero divide by 2");
  endtask

  task automatic t_div1024;
    restart(D1K);
    measure(1'b0, 512, "R5 bit16 with 1024 option");
    measure(1'b1, 256, "R5 bit16 without 1024 option");
  endtask

  task automatic t_priority;
    restart(17'h3);
    measure(1'b0, 4, "R6 bits 0 and 1 set");
    restart(PASS | 17'h1);
    measure(1'b0, 2, "R6 divisor beats pass-through");
  endtask

  task automatic t_pass;
    bit ok_hi = 1'b1;
    bit ok_lo = 1'b1;
    bit ok_st = 1'b1;
    restart(PASS);
    idle(4);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      if (sd_clk_a !== 1'b1) ok_hi = 1'b0;
      @(negedge clk); #2;
      if (sd_clk_a !== 1'b0) ok_lo = 1'b0;
      if (!(pr_a && pf_a)) ok_st = 1'b0;
    end
    chk(ok_hi, "R4 high with host clock", int'(ok_hi), 1);
    chk(ok_lo, "R4 low with host clock", int'(ok_lo), 1);
    chk(ok_st, "R4 strobes held", int'(ok_st), 1);
    wr(PASS);
    idle(5);
    ok_hi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      if (sd_clk_a !== 1'b0) ok_hi = 1'b0;
    end
    chk(ok_hi, "R4 pass-through stops low", int'(ok_hi), 1);
    wr(EN);
    measure(1'b0, 1, "R3 divide by 2 after pass-through");
  endtask

  task automatic t_ratio_hold;
    restart(17'h1);
    measure(1'b0, 2, "R9 running at /4");
    wr(17'h2 | EN);
    measure(1'b0, 2, "R9 new ratio held back");
    wr(17'h2);
    idle(20);
    wr(17'h2 | EN);
    measure(1'b0, 4, "R9 new ratio after restart");
  endtask

  task automatic t_disable;
    bit s, pr, pf;
    bit ps = 1'b0;
    int n = 0;
    int h2 = 0;
    restart(17'h4);
    sample(1'b0, ps, pr, pf);
    while (n < 100) begin
      sample(1'b0, s, pr, pf);
      n++;
      if (s && !ps) break;
      ps = s;
    end
    wr(17'h4);
    sample(1'b0, s, pr, pf);
    while (s && h2 < 50) begin
      h2++;
      sample(1'b0, s, pr, pf);
    end
    chk(3 + h2 == 8, "R7 high phase completes", 3 + h2, 8);
    expect_quiet(60, "R7 stays low after disable");
  endtask

  task automatic t_autostop;
    restart(17'h0);
    wr(17'h0);
    idle(10);
    bus_busy = 1'b0;
    wr(17'h1 | EN | AUTO);
    expect_quiet(20, "R8 parked while bus idle");
    bus_busy = 1'b1;
    measure(1'b0, 2, "R8 runs while bus busy");
    bus_busy = 1'b0;
    idle(10);
    expect_quiet(20, "R8 parks again");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_start();
    t_divisors();
    t_div2();
    t_div1024();
    t_priority();
    t_pass();
    t_ratio_hold();
    t_disable();
    t_autostop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule